// File: doc/BRIEF.md
# Look-Ahead Multiplier Recoder

This block walks a multiplier word from its top bit down to bit 0 and turns it into a short list of multiply steps. Each step has a shift count `s` and a sign `a` in {-1, 0, +1}. An external datapath applies a step as `Z := Z·2^s + a·C`, starting from `Z = 0`. When every step has been applied, `Z` equals `C·M`. Runs of equal bits are folded into one longer shift, so there are far fewer add or subtract operations than multiplier bits.

The recoder keeps a one-bit run state. In state 0 it is passing over zeros and any add it issues is positive. In state 1 it is passing over ones, having already added one unit ahead, and any operation it issues is a subtraction. Two zero bits are imagined below bit 0 so that the lookahead can always see two positions. The shift of a single step is capped by a run-time limit, which matches the reach of the barrel shifter. When a step stops at that cap, or at bit 0, it is a shift-only step.

A binary-field mode targets carry-less (XOR) accumulation. In that mode only zero runs are folded, the run state never leaves 0, and no step subtracts. Each step is offered on a valid/ready pair, so the datapath can stall the scan.

Top module: `lookahead_recoder`

## Requirements
- R1: After reset, `step_valid_o` and `done_o` are both low.
- R2: A cycle with `start_i` high captures the multiplier, length, shift limit and mode, and restarts the scan. In the cycle after it, `step_valid_o` and `done_o` are both low.
- R3: In prime-field mode, take the accepted steps in order and apply `Z := Z·2^shift + a·C` from `Z = 0`. The result is `C·M`, where M is the multiplier restricted to its low `len_i` bits.
- R4: `step_sign_o` uses a two-bit two's complement code: 2'b01 is +1 (add C), 2'b11 is -1 (subtract C), and 2'b00 is shift only. The code 2'b10 never appears.
- R5: `step_shift_o` never exceeds the captured shift limit, and a limit of 0 is treated as 1. A run longer than the limit is split into shift-only steps of exactly the limit. A shift-only step always has a nonzero shift.
- R6: In prime-field mode, a multiplier of L ones with a limit of at least L produces exactly two steps: (+1, 0) and then (-1, L).
- R7: An isolated bit costs one operation at its own position. Multiplier 4'b0100 yields (+1, 2), (0, 2). Multiplier 4'b1101 yields (+1, 0), (-1, 3), (-1, 1).
- R8: In binary-field mode (`bin_field_i = 1`), no step subtracts. Applying `Z := (Z << shift) XOR (a ? C : 0)` gives the carry-less product of C and M. A multiplier of L ones yields L steps of (+1, 1).
- R9: While `step_valid_o` is high and `step_ready_i` is low, the valid, sign and shift outputs hold their values. The next step appears only after the current one has been accepted.
- R10: After the last step is accepted, `done_o` rises and stays high with `step_valid_o` low until the next start. A length of 0 gives `done_o` with no steps.
- R11: Multiplier bits at or above `len_i` have no effect on the steps. A length above the word width is treated as the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture operands and begin a new scan |
| mult_i | input | W | Multiplier word |
| len_i | input | $clog2(W+1) | Number of valid multiplier bits |
| max_shift_i | input | SHW | Largest shift allowed in one step (0 acts as 1) |
| bin_field_i | input | 1 | 1: binary-field (carry-less) recoding, 0: prime-field |
| step_ready_i | input | 1 | Datapath accepts the offered step |
| step_valid_o | output | 1 | A step is offered |
| step_sign_o | output | 2 | Step sign: 01 add, 11 subtract, 00 shift only |
| step_shift_o | output | SHW | Step shift count |
| done_o | output | 1 | Scan finished; level until the next start |

## Verification
The bench replays every accepted step through an arithmetic or carry-less accumulator and compares the total against the true product. This catches a flipped run state or a dropped virtual bit, because either one leaves the result off by multiples of C. Exact step lists are checked for an all-ones word, an isolated one and an isolated zero. A recoder that issued one operation per bit boundary, or that skipped the lookahead toggle, would produce extra or misplaced steps there. Long zero runs under small limits, including a limit of 0, target a design that overshoots the cap or emits a zero-length shift-only step. Stalled handshakes and garbage above the length target outputs that drift while unaccepted and lengths that are not masked.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  typedef enum logic [1:0] {
    SGN_NONE = 2'b00,
    SGN_ADD  = 2'b01,
    SGN_SUB  = 2'b11
  } step_sign_e;

  typedef enum logic [2:0] {
    ACT_TOGGLE,
    ACT_SKIP,
    ACT_SKIP_EMIT,
    ACT_EMIT_NONE,
    ACT_FINISH
  } scan_act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HOLD
  } scan_st_e;

  function automatic step_sign_e sign_of(input logic run_one);
    return run_one ? SGN_SUB : SGN_ADD;
  endfunction

endpackage

// File: rtl/la_bit_window.sv
// Two-bit lookahead below the scan position; positions below 0 read as 0.
module la_bit_window #(
  parameter int W  = 64,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  input  logic [LW-1:0] pos_i,
  output logic          near_o,
  output logic          far_o,
  output logic          pos_zero_o
);
  localparam int IW = $clog2(W);

  logic [LW-1:0] pos_m1, pos_m2;

  always_comb begin
    pos_m1     = pos_i - LW'(1);
    pos_m2     = pos_i - LW'(2);
    pos_zero_o = (pos_i == '0);
    near_o     = (pos_i >= LW'(1)) ? word_i[IW'(pos_m1)] : 1'b0;
    far_o      = (pos_i >= LW'(2)) ? word_i[IW'(pos_m2)] : 1'b0;
  end
endmodule

// File: rtl/la_step_decide.sv
module la_step_decide
  import lookahead_pkg::*;
#(
  parameter int SHW = 4
) (
  input  logic           run_one_i,
  input  logic           near_i,
  input  logic           far_i,
  input  logic           pos_zero_i,
  input  logic           bin_i,
  input  logic [SHW-1:0] sz_i,
  input  logic [SHW-1:0] kmax_i,
  output scan_act_e      act_o
);
  logic both_differ, at_limit;

  always_comb begin
    both_differ = (near_i != run_one_i) && (far_i != run_one_i);
    at_limit    = (sz_i == kmax_i);
    if (!bin_i && both_differ) begin
      act_o = ACT_TOGGLE;
    end else if (!pos_zero_i && !at_limit) begin
      // consume one bit; keep going while it matches the run state
      act_o = (near_i == run_one_i) ? ACT_SKIP : ACT_SKIP_EMIT;
    end else if (pos_zero_i && !run_one_i && (sz_i == '0)) begin
      act_o = ACT_FINISH;
    end else begin
      act_o = ACT_EMIT_NONE;
    end
  end
endmodule

// File: rtl/lookahead_recoder.sv
module lookahead_recoder
  import lookahead_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = 4,
  localparam int LW = $clog2(W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   mult_i,
  input  logic [LW-1:0]  len_i,
  input  logic [SHW-1:0] max_shift_i,
  input  logic           bin_field_i,
  input  logic           step_ready_i,
  output logic           step_valid_o,
  output logic [1:0]     step_sign_o,
  output logic [SHW-1:0] step_shift_o,
  output logic           done_o
);

  scan_st_e       st_q;
  step_sign_e     sign_q;
  logic [W-1:0]   word_q;
  logic [LW-1:0]  pos_q;
  logic [SHW-1:0] sz_q, shift_q, kmax_q;
  logic           run_one_q, bin_q, done_q;

  logic           near, far, pos_zero;
  scan_act_e      act;
  logic [LW-1:0]  len_eff;
  logic [SHW-1:0] kmax_eff;

  assign len_eff  = (len_i > LW'(W)) ? LW'(W) : len_i;
  assign kmax_eff = (max_shift_i == '0) ? SHW'(1) : max_shift_i;

  la_bit_window #(.W(W), .LW(LW)) u_window (
    .word_i     (word_q),
    .pos_i      (pos_q),
    .near_o     (near),
    .far_o      (far),
    .pos_zero_o (pos_zero)
  );

  la_step_decide #(.SHW(SHW)) u_decide (
    .run_one_i  (run_one_q),
    .near_i     (near),
    .far_i      (far),
    .pos_zero_i (pos_zero),
    .bin_i      (bin_q),
    .sz_i       (sz_q),
    .kmax_i     (kmax_q),
    .act_o      (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sign_q    <= SGN_NONE;
      word_q    <= '0;
      pos_q     <= '0;
      sz_q      <= '0;
      shift_q   <= '0;
      kmax_q    <= SHW'(1);
      run_one_q <= 1'b0;
      bin_q     <= 1'b0;
      done_q    <= 1'b0;
    end else if (start_i) begin
      st_q      <= ST_SCAN;
      word_q    <= mult_i;
      pos_q     <= len_eff;
      sz_q      <= '0;
      kmax_q    <= kmax_eff;
      run_one_q <= 1'b0;
      bin_q     <= bin_field_i;
      done_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_SCAN: begin
          unique case (act)
            ACT_TOGGLE: begin
              run_one_q <= ~run_one_q;
              sign_q    <= sign_of(run_one_q);
              shift_q   <= sz_q;
              st_q      <= ST_HOLD;
            end
            ACT_SKIP: begin
              pos_q <= pos_q - LW'(1);
              sz_q  <= sz_q + SHW'(1);
            end
            ACT_SKIP_EMIT: begin
              pos_q   <= pos_q - LW'(1);
              sign_q  <= sign_of(run_one_q);
              shift_q <= sz_q + SHW'(1);
              st_q    <= ST_HOLD;
            end
            ACT_EMIT_NONE: begin
              sign_q  <= SGN_NONE;
              shift_q <= sz_q;
              st_q    <= ST_HOLD;
            end
            ACT_FINISH: begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_HOLD: begin
          if (step_ready_i) begin
            sz_q <= '0;
            st_q <= ST_SCAN;
          end
        end
        default: ;
      endcase
    end
  end

  assign step_valid_o = (st_q == ST_HOLD);
  assign step_sign_o  = sign_q;
  assign step_shift_o = shift_q;
  assign done_o       = done_q;

endmodule

// File: rtl/lookahead_recoder_chk.sv
module lookahead_recoder_chk #(
  parameter int SHW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           step_ready_i,
  input logic           step_valid_o,
  input logic [1:0]     step_sign_o,
  input logic [SHW-1:0] step_shift_o,
  input logic           done_o,
  input logic           bin_q,
  input logic [SHW-1:0] kmax_q
);

  assert_sign_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> (step_sign_o != 2'b10));

  assert_shift_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> (step_shift_o <= kmax_q));

  assert_shift_only_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_o && step_sign_o == 2'b00) |-> (step_shift_o != '0));

  assert_bin_no_sub_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_o && bin_q) |-> (step_sign_o != 2'b11));

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_valid_o && !step_ready_i && !start_i) |=>
      (step_valid_o && $stable(step_sign_o) && $stable(step_shift_o)));

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !step_valid_o);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !step_valid_o));

endmodule

bind lookahead_recoder lookahead_recoder_chk #(.SHW(SHW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .step_ready_i (step_ready_i),
  .step_valid_o (step_valid_o),
  .step_sign_o  (step_sign_o),
  .step_shift_o (step_shift_o),
  .done_o       (done_o),
  .bin_q        (bin_q),
  .kmax_q       (kmax_q)
);

// File: tb/lookahead_recoder_tb.sv
module lookahead_recoder_tb;
  localparam int W   = 64;
  localparam int SHW = 4;
  localparam int LW  = $clog2(W + 1);

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mult = '0;
  logic [LW-1:0]  len_in = '0;
  logic [SHW-1:0] kin = '0;
  logic           bin_in = 1'b0;
  logic           ready = 1'b0;
  logic           valid;
  logic [1:0]     sign;
  logic [SHW-1:0] shift;
  logic           done;

  int checks = 0;
  int errors = 0;

  logic [1:0]     st_sign [0:255];
  logic [SHW-1:0] st_shift[0:255];
  int             n_steps;
  int             stall_bad;
  bit             timed_out;

  always #2 clk = ~clk;

  lookahead_recoder #(.W(W), .SHW(SHW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .mult_i       (mult),
    .len_i        (len_in),
    .max_shift_i  (kin),
    .bin_field_i  (bin_in),
    .step_ready_i (ready),
    .step_valid_o (valid),
    .step_sign_o  (sign),
    .step_shift_o (shift),
    .done_o       (done)
  );

  function automatic void chk(input bit ok, input string req, input string what,
                              input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [127:0] replay(input bit bin_mode, input logic [127:0] c);
    logic [127:0] z = '0;
    for (int i = 0; i < n_steps; i++) begin
      z = z << st_shift[i];
      if (bin_mode) begin
        if (st_sign[i] != 2'b00) z = z ^ c;
      end else if (st_sign[i] == 2'b01) z = z + c;
      else if (st_sign[i] == 2'b11) z = z - c;
    end
    return z;
  endfunction

  function automatic logic [W-1:0] masked(input logic [W-1:0] m, input int len);
    if (len >= W) return m;
    return m & ((64'd1 << len) - 64'd1);
  endfunction

  task automatic run_scan(input logic [W-1:0] m, input int len, input int k,
                          input bit bin_mode, input bit stall);
    int cyc = 0;
    bit held = 0;
    logic [1:0] hs = '0;
    logic [SHW-1:0] hsh = '0;
    n_steps = 0; stall_bad = 0; timed_out = 0;
    @(negedge clk);
    mult = m; len_in = LW'(len); kin = SHW'(k); bin_in = bin_mode; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(!valid && !done, "R2", "idle after start", {valid, done}, 0);
    while (!done && cyc < 4000) begin
      if (held && (!valid || sign != hs || shift != hsh)) stall_bad++;
      ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (valid && ready && n_steps < 256) begin
        st_sign[n_steps]  = sign;
        st_shift[n_steps] = shift;
        n_steps++;
      end
      held = valid && !ready; hs = sign; hsh = shift;
      cyc++;
      @(negedge clk);
    end
    ready = 1'b0;
    timed_out = !done;
    chk(!timed_out, "R10", "scan reaches done", done, 1);
  endtask

  task automatic check_legal(input string req, input int k, input bit bin_mode);
    int keff = (k == 0) ? 1 : k;
    int bad = 0;
    for (int i = 0; i < n_steps; i++) begin
      if (st_sign[i] == 2'b10) bad++;
      if (int'(st_shift[i]) > keff) bad++;
      if (st_sign[i] == 2'b00 && st_shift[i] == 0) bad++;
      if (bin_mode && st_sign[i] == 2'b11) bad++;
    end
    chk(bad == 0, req, "illegal step fields", bad, 0);
  endtask

  task automatic test_product(input logic [W-1:0] m, input int len, input int k,
                              input bit bin_mode, input bit stall, input logic [31:0] c);
    logic [127:0] exp = '0;
    logic [W-1:0] mm = masked(m, len);
    run_scan(m, len, k, bin_mode, stall);
    if (bin_mode) begin
      for (int i = 0; i < W; i++) if (mm[i]) exp = exp ^ ({96'b0, c} << i);
      chk(replay(1'b1, {96'b0, c}) == exp, "R8", "carry-less product", replay(1'b1, {96'b0, c}), exp);
    end else begin
      exp = {96'b0, c} * {64'b0, mm};
      chk(replay(1'b0, {96'b0, c}) == exp, "R3", "product", replay(1'b0, {96'b0, c}), exp);
    end
    check_legal(bin_mode ? "R8" : "R5", k, bin_mode);
    if (stall) chk(stall_bad == 0, "R9", "stalled step drifted", stall_bad, 0);
  endtask

  task automatic test_reset;
    chk(!valid && !done, "R1", "reset outputs", {valid, done}, 0);
  endtask

  task automatic test_all_ones;
    run_scan(64'hFF, 8, 15, 1'b0, 1'b0);
    chk(n_steps == 2, "R6", "step count", n_steps, 2);
    chk(st_sign[0] == 2'b01 && st_shift[0] == 0, "R6", "first step", {st_sign[0], st_shift[0]}, {2'b01, 4'd0});
    chk(st_sign[1] == 2'b11 && st_shift[1] == 8, "R6", "second step", {st_sign[1], st_shift[1]}, {2'b11, 4'd8});
  endtask

  task automatic test_isolated;
    run_scan(64'b0100, 4, 15, 1'b0, 1'b0);
    chk(n_steps == 2 && st_sign[0] == 2'b01 && st_shift[0] == 2 && st_sign[1] == 2'b00 && st_shift[1] == 2,
        "R7", "isolated one", {n_steps[7:0], st_sign[0], st_shift[0], st_sign[1], st_shift[1]},
        {8'd2, 2'b01, 4'd2, 2'b00, 4'd2});
    run_scan(64'b1101, 4, 15, 1'b0, 1'b1);
    chk(n_steps == 3 && st_sign[0] == 2'b01 && st_shift[0] == 0 && st_sign[1] == 2'b11 && st_shift[1] == 3
        && st_sign[2] == 2'b11 && st_shift[2] == 1, "R7", "isolated zero",
        {n_steps[7:0], st_sign[0], st_shift[0], st_sign[1], st_shift[1], st_sign[2], st_shift[2]},
        {8'd3, 2'b01, 4'd0, 2'b11, 4'd3, 2'b11, 4'd1});
  endtask

  task automatic test_limits;
    run_scan(64'h0, 10, 4, 1'b0, 1'b0);
    chk(n_steps == 3 && st_shift[0] == 4 && st_shift[1] == 4 && st_shift[2] == 2
        && st_sign[0] == 2'b00 && st_sign[2] == 2'b00, "R5", "zero run split",
        {n_steps[7:0], st_shift[0], st_shift[1], st_shift[2]}, {8'd3, 4'd4, 4'd4, 4'd2});
    run_scan(64'h0, 3, 0, 1'b0, 1'b0);
    chk(n_steps == 3 && st_shift[0] == 1 && st_shift[2] == 1, "R5", "limit 0 acts as 1",
        {n_steps[7:0], st_shift[0], st_shift[2]}, {8'd3, 4'd1, 4'd1});
    run_scan(64'hFFFF, 16, 3, 1'b0, 1'b0);
    check_legal("R5", 3, 1'b0);
    chk(replay(1'b0, 128'd1) == 128'hFFFF, "R5", "capped ones run value", replay(1'b0, 128'd1), 128'hFFFF);
  endtask

  task automatic test_done_and_len;
    run_scan(64'hDEAD, 0, 5, 1'b0, 1'b0);
    chk(n_steps == 0, "R10", "length 0 gives no steps", n_steps, 0);
    repeat (3) @(negedge clk);
    chk(done && !valid, "R10", "done holds", {done, valid}, 2'b10);
    run_scan(64'hFFFF_FFFF_FFFF_FF05, 8, 15, 1'b0, 1'b0);
    chk(replay(1'b0, 128'd1) == 128'h05, "R11", "bits above length ignored", replay(1'b0, 128'd1), 128'h05);
    test_product(64'h8000_0000_0000_0001, 100, 7, 1'b0, 1'b0, 32'h1234_5679);
  endtask

  task automatic test_binary;
    run_scan(64'h3F, 6, 15, 1'b1, 1'b0);
    begin
      int bad = 0;
      for (int i = 0; i < n_steps; i++) if (st_sign[i] != 2'b01 || st_shift[i] != 1) bad++;
      chk(n_steps == 6 && bad == 0, "R8", "ones in binary mode", {n_steps[7:0], bad[7:0]}, {8'd6, 8'd0});
    end
    test_product(64'hA5A5_0F0F_3C3C_FFFF, 64, 5, 1'b1, 1'b1, 32'hCAFE_F00D);
  endtask

  task automatic test_patterns;
    test_product(64'hAAAA_AAAA_AAAA_AAAA, 64, 15, 1'b0, 1'b0, 32'h9E37_79B9);
    test_product(64'h5555_5555_5555_5555, 64, 2, 1'b0, 1'b1, 32'h0000_0003);
    test_product(64'hFFFF_FFFF_FFFF_FFFF, 64, 15, 1'b0, 1'b1, 32'hFFFF_FFFF);
    test_product(64'h0, 64, 9, 1'b0, 1'b0, 32'h7);
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] m = {$urandom, $urandom};
      test_product(m, 1 + ($urandom % 64), $urandom % 16, i[0], i[1], $urandom);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_all_ones();
    test_isolated();
    test_limits();
    test_done_and_len();
    test_binary();
    test_patterns();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule